// File: doc/BRIEF.md
# Frame-Locked PWM Period Regulator

This block steers the period of a PWM generator so that a chosen whole number of PWM cycles fits into each video frame. It sees two pulse streams: one marking the end of every PWM cycle, and a vertical-sync pulse marking every frame boundary. Between frame boundaries it counts cycle ends, and at each boundary it publishes that count.

In measuring mode the block only counts. It passes the programmed base period straight through and keeps the most recent per-frame count as a stored target. In tracking mode, at every frame boundary it takes the difference between the frame's count and a target. The target is either the stored count or a programmed value. A proportional-plus-integral filter built only from arithmetic shifts turns that difference into a correction on the base period. The output period is clamped to the representable range. A status flag reports when the count has matched the target for several frames in a row.

The waveform generator that consumes the period is a separate block.

Top module: `plm_period_lock`

## Requirements
- R1: While and after reset, until the first event, `period_out` equals `base_period`, `locked` is 0 and `frame_count` is 0.
- R2: At each `vsync` pulse, `frame_count` takes the number of `cyc_end` pulses seen since the previous `vsync` (or since reset). A `cyc_end` in the same cycle as `vsync` belongs to the frame that ends there. Between `vsync` pulses, `frame_count` does not change.
- R3: With `track_en` = 0, `period_out` equals `base_period` as sampled one clock earlier.
- R4: `tgt_src` = 0 makes the target the count latched at the last `vsync` that arrived while `track_en` was 0. `tgt_src` = 1 makes the target `tgt_count`.
- R5: At a `vsync` with `track_en` = 1, the block computes err = frame count − target. It then updates integ += err >>> `ki_shift` and sets `period_out` = `base_period` + integ + (err >>> `kp_shift`). Both shifts are arithmetic, so shift 0 gives the largest gain and 15 the smallest.
- R6: With `track_en` = 1, `period_out` changes only in the cycle after a `vsync`.
- R7: `period_out` saturates to the range 0 to 2^PW−1.
- R8: `locked` rises after LOCK_FRAMES consecutive tracking-mode frames with zero error. It falls at the first frame with nonzero error, and it changes only after a `vsync`.
- R9: Dropping `track_en` to 0 clears `locked` and the integrator on the next clock, so the next tracking frame starts from a zero integral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_end | input | 1 | One-cycle pulse at the end of each PWM cycle |
| vsync | input | 1 | One-cycle frame boundary pulse |
| track_en | input | 1 | 0 = measure only, 1 = track target |
| tgt_src | input | 1 | 0 = stored measured count, 1 = `tgt_count` |
| tgt_count | input | CW (16) | Programmed target cycles per frame |
| base_period | input | PW (16) | Nominal PWM period in clocks |
| kp_shift | input | GW (4) | Proportional gain shift |
| ki_shift | input | GW (4) | Integral gain shift |
| period_out | output | PW (16) | Corrected PWM period |
| locked | output | 1 | Frame lock status |
| frame_count | output | CW (16) | Cycle count of the last completed frame |

## Verification
The bench builds the block with its default parameters: 16-bit period and count, a 24-bit integrator and LOCK_FRAMES = 4. With these values the lock flag can be brought up in a few short frames of about a hundred cycles each. A base period near 0xFFFF, or near zero, reaches either saturation rail with a frame error of a few tens of cycles. Small gain shifts make the shift rounding of negative errors visible in the period.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef enum logic {MODE_MEASURE = 1'b0, MODE_TRACK = 1'b1} plm_mode_e;
  typedef enum logic {SRC_MEASURED = 1'b0, SRC_PROGRAMMED = 1'b1} plm_src_e;
endpackage

// File: rtl/plm_frame_counter.sv
module plm_frame_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_end,
  input  logic          vsync,
  input  logic          capture_en,
  output logic [CW-1:0] total_now,
  output logic [CW-1:0] frame_q,
  output logic [CW-1:0] capt_q
);
  localparam logic [CW-1:0] CMAX = '1;
  logic [CW-1:0] cnt;

  // running count including a pulse in this very cycle, saturating
  always_comb begin
    total_now = (cyc_end && (cnt != CMAX)) ? cnt + 1'b1 : cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      frame_q <= '0;
      capt_q  <= '0;
    end else if (vsync) begin
      cnt     <= '0;
      frame_q <= total_now;
      if (capture_en) capt_q <= total_now;
    end else begin
      cnt <= total_now;
    end
  end
endmodule

// File: rtl/plm_loop_filter.sv
module plm_loop_filter #(
  parameter int PW = 16,
  parameter int EW = 17,
  parameter int IW = 24,
  parameter int GW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 upd,
  input  logic signed [EW-1:0] err,
  input  logic [GW-1:0]        kp_shift,
  input  logic [GW-1:0]        ki_shift,
  input  logic [PW-1:0]        base,
  output logic [PW-1:0]        period_q
);
  localparam logic signed [IW:0]   IMAX = {2'b00, {(IW-1){1'b1}}};
  localparam logic signed [IW:0]   IMIN = {2'b11, {(IW-1){1'b0}}};
  localparam logic signed [IW+1:0] PMAX = {{(IW+2-PW){1'b0}}, {PW{1'b1}}};

  logic signed [IW-1:0] integ, integ_new, e_x, p_term, i_step;
  logic signed [IW:0]   i_sum, corr;
  logic signed [IW+1:0] p_sum;
  logic [PW-1:0]        p_clamped;

  always_comb begin
    e_x    = {{(IW-EW){err[EW-1]}}, err};
    p_term = e_x >>> kp_shift;
    i_step = e_x >>> ki_shift;
    i_sum  = {integ[IW-1], integ} + {i_step[IW-1], i_step};
    if (i_sum > IMAX)      integ_new = IMAX[IW-1:0];
    else if (i_sum < IMIN) integ_new = IMIN[IW-1:0];
    else                   integ_new = i_sum[IW-1:0];
    corr  = {integ_new[IW-1], integ_new} + {p_term[IW-1], p_term};
    p_sum = $signed({{(IW+2-PW){1'b0}}, base}) + {corr[IW], corr};
    if (p_sum < 0)         p_clamped = '0;
    else if (p_sum > PMAX) p_clamped = '1;
    else                   p_clamped = p_sum[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      integ    <= '0;
      period_q <= base;
    end else if (upd) begin
      integ    <= integ_new;
      period_q <= p_clamped;
    end
  end
endmodule

// File: rtl/plm_lock_detect.sv
module plm_lock_detect #(
  parameter int LOCK_FRAMES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic upd,
  input  logic err_zero,
  output logic locked_q
);
  localparam int SW = $clog2(LOCK_FRAMES + 1);
  localparam logic [SW-1:0] LF = SW'(LOCK_FRAMES);
  logic [SW-1:0] streak, streak_nx;

  always_comb begin
    streak_nx = streak;
    if (upd) begin
      if (!err_zero)        streak_nx = '0;
      else if (streak != LF) streak_nx = streak + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      streak   <= '0;
      locked_q <= 1'b0;
    end else begin
      streak   <= streak_nx;
      locked_q <= (streak_nx == LF);
    end
  end
endmodule

// File: rtl/plm_period_lock.sv
module plm_period_lock #(
  parameter int PW          = 16,
  parameter int CW          = 16,
  parameter int IW          = 24,
  parameter int GW          = 4,
  parameter int LOCK_FRAMES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_end,
  input  logic          vsync,
  input  logic          track_en,
  input  logic          tgt_src,
  input  logic [CW-1:0] tgt_count,
  input  logic [PW-1:0] base_period,
  input  logic [GW-1:0] kp_shift,
  input  logic [GW-1:0] ki_shift,
  output logic [PW-1:0] period_out,
  output logic          locked,
  output logic [CW-1:0] frame_count
);
  import plm_pkg::*;
  localparam int EW = CW + 1;

  plm_mode_e          mode;
  plm_src_e           src;
  logic [CW-1:0]      total_now, capt_q, target;
  logic signed [EW-1:0] err;
  logic               upd;

  assign mode   = plm_mode_e'(track_en);
  assign src    = plm_src_e'(tgt_src);
  assign target = (src == SRC_PROGRAMMED) ? tgt_count : capt_q;
  assign err    = $signed({1'b0, total_now}) - $signed({1'b0, target});
  assign upd    = vsync && (mode == MODE_TRACK);

  plm_frame_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .cyc_end(cyc_end), .vsync(vsync),
    .capture_en(mode == MODE_MEASURE), .total_now(total_now),
    .frame_q(frame_count), .capt_q(capt_q)
  );

  plm_loop_filter #(.PW(PW), .EW(EW), .IW(IW), .GW(GW)) u_filt (
    .clk(clk), .rst(rst), .run(mode == MODE_TRACK), .upd(upd), .err(err),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .base(base_period),
    .period_q(period_out)
  );

  plm_lock_detect #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk(clk), .rst(rst), .run(mode == MODE_TRACK), .upd(upd),
    .err_zero(err == '0), .locked_q(locked)
  );
endmodule

// File: rtl/plm_period_lock_chk.sv
module plm_period_lock_chk #(
  parameter int PW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          vsync,
  input logic          track_en,
  input logic [PW-1:0] base_period,
  input logic [PW-1:0] period_out,
  input logic          locked,
  input logic [CW-1:0] frame_count
);
  a_r3_measure_passes_base: assert property (@(posedge clk) disable iff (rst)
    !track_en |=> (period_out == $past(base_period)));
  a_r9_exit_clears_lock: assert property (@(posedge clk) disable iff (rst)
    !track_en |=> !locked);
  a_r6_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
    (track_en && !vsync) |=> $stable(period_out));
  a_r8_lock_moves_at_vsync: assert property (@(posedge clk) disable iff (rst)
    (track_en && !vsync) |=> $stable(locked));
  a_r8_rise_after_vsync: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(vsync && track_en));
  a_r2_count_steady: assert property (@(posedge clk) disable iff (rst)
    !vsync |=> $stable(frame_count));
endmodule

bind plm_period_lock plm_period_lock_chk #(.PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .vsync(vsync), .track_en(track_en),
  .base_period(base_period), .period_out(period_out), .locked(locked),
  .frame_count(frame_count)
);

// File: tb/plm_period_lock_bench.sv
module plm_period_lock_bench;
  localparam int PW = 16, CW = 16, IW = 24, GW = 4, LOCK_FRAMES = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_end = 1'b0, vsync = 1'b0, track_en = 1'b0, tgt_src = 1'b0;
  logic [CW-1:0] tgt_count = '0;
  logic [PW-1:0] base_period = 16'd1000;
  logic [GW-1:0] kp_shift = '0, ki_shift = '0;
  logic [PW-1:0] period_out;
  logic          locked;
  logic [CW-1:0] frame_count;

  int n_checks = 0, n_fail = 0;
  int m_capt = 0, m_integ = 0, m_period = 1000, m_streak = 0, m_locked = 0, m_meas = 0;

  always #4 clk = ~clk;

  plm_period_lock #(.PW(PW), .CW(CW), .IW(IW), .GW(GW), .LOCK_FRAMES(LOCK_FRAMES))
  u_plm_period_lock (
    .clk(clk), .rst(rst), .cyc_end(cyc_end), .vsync(vsync), .track_en(track_en),
    .tgt_src(tgt_src), .tgt_count(tgt_count), .base_period(base_period),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .period_out(period_out),
    .locked(locked), .frame_count(frame_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clamp(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // model of one frame boundary, following R2, R4, R5, R7, R8
  task automatic model_vsync(input int n);
    int tgt, err;
    m_meas = n;
    if (!track_en) begin
      m_capt = n;
    end else begin
      tgt = tgt_src ? int'(tgt_count) : m_capt;
      err = n - tgt;
      m_integ  = clamp(m_integ + (err >>> ki_shift), -(1 << (IW-1)), (1 << (IW-1)) - 1);
      m_period = clamp(int'(base_period) + m_integ + (err >>> kp_shift), 0, (1 << PW) - 1);
      if (err != 0) m_streak = 0;
      else if (m_streak < LOCK_FRAMES) m_streak++;
      m_locked = (m_streak == LOCK_FRAMES);
    end
  endtask

  task automatic frame(input int n, input bit coincide, input string tag);
    for (int i = 0; i < n - (coincide ? 1 : 0); i++) begin
      @(negedge clk) cyc_end = 1'b1;
      @(negedge clk) cyc_end = 1'b0;
    end
    @(negedge clk); vsync = 1'b1; cyc_end = coincide;
    @(negedge clk); vsync = 1'b0; cyc_end = 1'b0;
    model_vsync(n);
    check({tag, " count"}, int'(frame_count), m_meas);
    check({tag, " period"}, int'(period_out), track_en ? m_period : int'(base_period));
    check({tag, " locked"}, int'(locked), track_en ? m_locked : 0);
  endtask

  task automatic leave_track();
    @(negedge clk) track_en = 1'b0;
    m_integ = 0; m_streak = 0; m_locked = 0;
    @(negedge clk);
    check("R9 period back to base", int'(period_out), int'(base_period));
    check("R9 lock cleared", int'(locked), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset period", int'(period_out), 1000);
    check("R1 reset locked", int'(locked), 0);
    check("R1 reset count", int'(frame_count), 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1 after reset period", int'(period_out), 1000);

    // measuring mode
    frame(100, 1'b0, "R2 measure");
    frame(100, 1'b1, "R2 coincident pulse");
    @(negedge clk) base_period = 16'd1234;
    @(negedge clk) check("R3 base follows", int'(period_out), 1234);
    @(negedge clk) base_period = 16'd1000;
    frame(100, 1'b0, "R3 measure capture");

    // track stored count; lock after LOCK_FRAMES zero-error frames
    @(negedge clk) begin track_en = 1'b1; tgt_src = 1'b0; kp_shift = 4'd0; ki_shift = 4'd2; end
    for (int f = 0; f < LOCK_FRAMES; f++) frame(100, 1'b0, "R8 R4 zero error");
    check("R8 locked after run", int'(locked), 1);
    frame(103, 1'b0, "R5 positive error");
    check("R8 unlock on error", int'(locked), 0);
    check("R5 period base+3", int'(period_out), 1003);
    frame(98, 1'b0, "R5 negative error");

    // random frames against programmed target
    @(negedge clk) begin tgt_src = 1'b1; tgt_count = 16'd80; end
    for (int f = 0; f < 24; f++) begin
      @(negedge clk) begin
        kp_shift = GW'($urandom_range(0, 3));
        ki_shift = GW'($urandom_range(0, 5));
      end
      frame(76 + int'($urandom_range(0, 8)), 1'b0, "R4 R5 random");
    end
    for (int f = 0; f < LOCK_FRAMES; f++) frame(80, 1'b0, "R8 programmed target");
    check("R8 R4 lock to programmed", int'(locked), 1);

    // R9 exit and fresh integral
    leave_track();
    frame(60, 1'b0, "R9 measure again");
    @(negedge clk) begin track_en = 1'b1; tgt_src = 1'b0; kp_shift = 4'd1; ki_shift = 4'd0; end
    frame(55, 1'b0, "R9 fresh integral");
    check("R9 first correction", int'(period_out), 1000 - 5 - 3);

    // R7 saturation at both rails
    leave_track();
    @(negedge clk) begin base_period = 16'hFFF0; track_en = 1'b1; tgt_src = 1'b1;
      tgt_count = 16'd10; kp_shift = 4'd0; ki_shift = 4'd0; end
    frame(40, 1'b0, "R7 upper");
    check("R7 clamp high", int'(period_out), 65535);
    leave_track();
    @(negedge clk) begin base_period = 16'd5; track_en = 1'b1; tgt_count = 16'd60; end
    frame(0, 1'b0, "R7 lower");
    check("R7 clamp low", int'(period_out), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule